// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block lets any CPU in a cluster raise a software-generated inter-processor interrupt, numbered 0 to 15, toward a set of CPUs with one 32-bit trigger write. For every pairing of interrupt number and target CPU, the block keeps a bitmap of the CPUs that asked for it. If several CPUs request the same interrupt toward the same target, each request is kept on its own. The target later receives them one at a time.

A target CPU acknowledges an interrupt number and gets back a response word one cycle later. The word carries the interrupt number and one requesting source CPU, and that source is retired from the bitmap. The pending flag of a pairing is high while any source remains in its bitmap. Two byte-wide maintenance writes, set and clear, let software add or remove source bits directly. Priority arbitration, enables and peripheral interrupts are handled elsewhere.

Top module: `sgi_source_tracker`

## Requirements
- R1: After reset every pending flag is 0 and `ackRvalid` is 0.
- R2: A trigger write takes the interrupt number from `trigData[3:0]` and the target filter from `trigData[25:24]`. Filter 0 targets exactly the CPUs whose bits are set in `trigData[23:16]`, and list bits at or above `NUM_CPU` are ignored. Each targeted pairing records the writer in its source bitmap. `pending[cpu*16+id]` rises at the clock edge that accepts the write.
- R3: Filter 1 targets every CPU except the writer.
- R4: Filter 2 targets only the writer.
- R5: Filter 3 targets all `NUM_CPU` CPUs.
- R6: A trigger write whose target set is empty changes no pending flag and no bitmap.
- R7: An acknowledge presented at an edge gives `ackRvalid` high after that edge. `ackRdata` then holds the interrupt number in bits [3:0], the source CPU in bits [12:10] and zeros elsewhere. The source returned is the lowest-numbered set bit of the bitmap, and that bit is removed.
- R8: The pending flag of a pairing stays high until its last source is acknowledged, and it falls at that same edge.
- R9: Acknowledging a pairing whose bitmap is empty returns 0x3FF and changes nothing.
- R10: A set-maintenance write ORs `bankBits` into the bitmap of (`bankCpu`, `bankSgi`) and raises that pairing's pending flag when the result is non-empty.
- R11: A clear-maintenance write removes the bits of `bankBits` from the bitmap. The pending flag falls only when the bitmap becomes empty. Clearing bits that are not set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigValid | input | 1 | Trigger write strobe |
| trigCpu | input | 3 | CPU issuing the trigger write |
| trigData | input | 32 | Trigger word: id [3:0], target list [23:16], filter [25:24] |
| ackValid | input | 1 | Acknowledge strobe |
| ackCpu | input | 3 | Acknowledging target CPU |
| ackSgi | input | 4 | Interrupt number being acknowledged |
| bankSetValid | input | 1 | Set-maintenance byte write strobe |
| bankClrValid | input | 1 | Clear-maintenance byte write strobe |
| bankCpu | input | 3 | Target CPU of the maintenance write |
| bankSgi | input | 4 | Interrupt number of the maintenance write |
| bankBits | input | 8 | Source bits to add or remove |
| ackRvalid | output | 1 | Acknowledge response valid |
| ackRdata | output | 32 | Acknowledge response word |
| pending | output | NUM_CPU*16 | Pending flag per pairing, index cpu*16+id |

## Verification
The hardest case to reach is a single pairing that holds several sources at once, so that delivery order and the moment the pending flag falls can both be seen. The stimulus builds this up with trigger writes from three different CPUs to one target and one interrupt number, issued out of numeric order. It then acknowledges three times and checks the source sequence and the pending flag after each acknowledge. A fourth acknowledge and clear writes of bits that were never set confirm that an empty or partial bitmap behaves as required.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int CPU_MAX   = 8;
  localparam int SGI_COUNT = 16;
  localparam int CPU_W     = $clog2(CPU_MAX);
  localparam int SGI_W     = $clog2(SGI_COUNT);

  typedef struct packed {
    logic               trigEn;
    logic [SGI_W-1:0]   trigSgi;
    logic [CPU_MAX-1:0] trigSrc;
    logic [CPU_MAX-1:0] trigDst;
    logic               bankSet;
    logic               bankClr;
    logic [SGI_W-1:0]   bankSgi;
    logic [CPU_MAX-1:0] bankDst;
    logic [CPU_MAX-1:0] bankBits;
    logic               ackEn;
    logic [SGI_W-1:0]   ackSgi;
    logic [CPU_MAX-1:0] ackDst;
  } sgiStrobes_t;
endpackage

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic              trigValid,
  input  logic [CPU_W-1:0]  trigCpu,
  input  logic [31:0]       trigData,
  input  logic              ackValid,
  input  logic [CPU_W-1:0]  ackCpu,
  input  logic [SGI_W-1:0]  ackSgi,
  input  logic              bankSetValid,
  input  logic              bankClrValid,
  input  logic [CPU_W-1:0]  bankCpu,
  input  logic [SGI_W-1:0]  bankSgi,
  input  logic [7:0]        bankBits,
  output sgiStrobes_t       strb
);
  localparam logic [CPU_MAX:0]   CPU_ONES = (CPU_MAX+1)'((1 << NUM_CPU) - 1);
  localparam logic [CPU_MAX-1:0] CPU_MASK = CPU_ONES[CPU_MAX-1:0];

  logic [CPU_MAX-1:0] writerHot;
  logic [CPU_MAX-1:0] dstSel;
  logic               unusedTrigBits;

  assign unusedTrigBits = ^{trigData[31:26], trigData[15:SGI_W]};

  always_comb begin
    writerHot = CPU_MASK & (CPU_MAX'(1) << trigCpu);
    unique case (trigData[25:24])
      2'd0:    dstSel = trigData[23:16];
      2'd1:    dstSel = ~writerHot;
      2'd2:    dstSel = writerHot;
      default: dstSel = '1;
    endcase
    dstSel = dstSel & CPU_MASK;

    strb.trigEn   = trigValid && (|dstSel) && (|writerHot);
    strb.trigSgi  = trigData[SGI_W-1:0];
    strb.trigSrc  = writerHot;
    strb.trigDst  = dstSel;
    strb.bankSet  = bankSetValid;
    strb.bankClr  = bankClrValid;
    strb.bankSgi  = bankSgi;
    strb.bankDst  = CPU_MASK & (CPU_MAX'(1) << bankCpu);
    strb.bankBits = bankBits & CPU_MASK;
    strb.ackEn    = ackValid;
    strb.ackSgi   = ackSgi;
    strb.ackDst   = CPU_MASK & (CPU_MAX'(1) << ackCpu);
  end
endmodule

// File: rtl/sgi_store.sv
module sgi_store
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sgiStrobes_t               strb,
  output logic [NUM_CPU*SGI_COUNT-1:0] pending,
  output logic                      ackRvalid,
  output logic [31:0]               ackRdata
);
  localparam int ENTRIES = NUM_CPU * SGI_COUNT;

  logic [ENTRIES*CPU_MAX-1:0] mapFlat;
  logic [CPU_MAX-1:0]         selMap;
  logic [CPU_MAX-1:0]         pickHot;
  logic [CPU_W-1:0]           pickIdx;
  logic                       pickFound;

  always_comb begin
    selMap = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int s = 0; s < SGI_COUNT; s++) begin
        if (strb.ackDst[c] && strb.ackSgi == SGI_W'(s))
          selMap = mapFlat[(c*SGI_COUNT+s)*CPU_MAX +: CPU_MAX];
      end
    end
    pickIdx = '0;
    for (int b = CPU_MAX-1; b >= 0; b--) begin
      if (selMap[b]) pickIdx = CPU_W'(b);
    end
    pickFound = |selMap;
    pickHot   = pickFound ? (CPU_MAX'(1) << pickIdx) : '0;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
    for (genvar s = 0; s < SGI_COUNT; s++) begin : gSgi
      logic [CPU_MAX-1:0] cur;
      logic [CPU_MAX-1:0] nxt;

      always_comb begin
        nxt = cur;
        if (strb.trigEn && strb.trigDst[c] && strb.trigSgi == SGI_W'(s))
          nxt = nxt | strb.trigSrc;
        if (strb.bankSet && strb.bankDst[c] && strb.bankSgi == SGI_W'(s))
          nxt = nxt | strb.bankBits;
        if (strb.bankClr && strb.bankDst[c] && strb.bankSgi == SGI_W'(s))
          nxt = nxt & ~strb.bankBits;
        if (strb.ackEn && strb.ackDst[c] && strb.ackSgi == SGI_W'(s))
          nxt = nxt & ~pickHot;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cur <= '0;
        else       cur <= nxt;
      end

      assign mapFlat[(c*SGI_COUNT+s)*CPU_MAX +: CPU_MAX] = cur;
      assign pending[c*SGI_COUNT+s] = |cur;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackRvalid <= 1'b0;
      ackRdata  <= '0;
    end else begin
      ackRvalid <= strb.ackEn;
      if (strb.ackEn) begin
        if (pickFound) ackRdata <= {19'd0, pickIdx, 6'd0, strb.ackSgi};
        else           ackRdata <= 32'h3FF;
      end
    end
  end
endmodule

// File: rtl/sgi_source_tracker.sv
module sgi_source_tracker
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         trigValid,
  input  logic [2:0]                   trigCpu,
  input  logic [31:0]                  trigData,
  input  logic                         ackValid,
  input  logic [2:0]                   ackCpu,
  input  logic [3:0]                   ackSgi,
  input  logic                         bankSetValid,
  input  logic                         bankClrValid,
  input  logic [2:0]                   bankCpu,
  input  logic [3:0]                   bankSgi,
  input  logic [7:0]                   bankBits,
  output logic                         ackRvalid,
  output logic [31:0]                  ackRdata,
  output logic [NUM_CPU*16-1:0]        pending
);
  sgiStrobes_t strb;

  sgi_ctrl #(.NUM_CPU(NUM_CPU)) uCtrl (
    .trigValid(trigValid), .trigCpu(trigCpu), .trigData(trigData),
    .ackValid(ackValid), .ackCpu(ackCpu), .ackSgi(ackSgi),
    .bankSetValid(bankSetValid), .bankClrValid(bankClrValid),
    .bankCpu(bankCpu), .bankSgi(bankSgi), .bankBits(bankBits),
    .strb(strb)
  );

  sgi_store #(.NUM_CPU(NUM_CPU)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pending(pending), .ackRvalid(ackRvalid), .ackRdata(ackRdata)
  );
endmodule

// File: rtl/sgi_checker.sv
module sgi_checker #(
  parameter int NUM_CPU = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  trigValid,
  input logic                  ackValid,
  input logic [2:0]            ackCpu,
  input logic [3:0]            ackSgi,
  input logic                  bankSetValid,
  input logic                  bankClrValid,
  input logic                  ackRvalid,
  input logic [31:0]           ackRdata,
  input logic [NUM_CPU*16-1:0] pending
);
  logic selPend;
  logic anyOp;

  always_comb begin
    selPend = 1'b0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int s = 0; s < 16; s++)
        if (ackCpu == 3'(c) && ackSgi == 4'(s)) selPend = pending[c*16+s];
  end

  assign anyOp = trigValid || ackValid || bankSetValid || bankClrValid;

  assert_ack_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> ackRvalid);
  assert_ack_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |=> !ackRvalid);
  assert_ack_format_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackRvalid && ackRdata != 32'h3FF) |->
      (ackRdata[31:13] == '0 && ackRdata[9:4] == '0 && ackRdata[3:0] == $past(ackSgi)));
  assert_empty_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> ((ackRdata == 32'h3FF) == !$past(selPend)));
  assert_rise_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(pending & ~$past(pending))) |-> $past(trigValid || bankSetValid));
  assert_fall_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(~pending & $past(pending))) |-> $past(ackValid || bankClrValid));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !anyOp |=> $stable(pending));
endmodule

bind sgi_source_tracker sgi_checker #(.NUM_CPU(NUM_CPU)) uChecker (
  .clk(clk), .rstN(rstN), .trigValid(trigValid), .ackValid(ackValid),
  .ackCpu(ackCpu), .ackSgi(ackSgi), .bankSetValid(bankSetValid),
  .bankClrValid(bankClrValid), .ackRvalid(ackRvalid), .ackRdata(ackRdata),
  .pending(pending)
);

// File: tb/sgi_source_tracker_test.sv
module sgi_source_tracker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigValid = 1'b0;
  logic [2:0]  trigCpu = '0;
  logic [31:0] trigData = '0;
  logic        ackValid = 1'b0;
  logic [2:0]  ackCpu = '0;
  logic [3:0]  ackSgi = '0;
  logic        bankSetValid = 1'b0;
  logic        bankClrValid = 1'b0;
  logic [2:0]  bankCpu = '0;
  logic [3:0]  bankSgi = '0;
  logic [7:0]  bankBits = '0;
  logic        ackRvalid;
  logic [31:0] ackRdata;
  logic [127:0] pending;

  int checks = 0;
  int fails = 0;
  logic [7:0] mdl [16][8];

  always #4 clk = ~clk;

  sgi_source_tracker uut (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigCpu(trigCpu),
    .trigData(trigData), .ackValid(ackValid), .ackCpu(ackCpu), .ackSgi(ackSgi),
    .bankSetValid(bankSetValid), .bankClrValid(bankClrValid), .bankCpu(bankCpu),
    .bankSgi(bankSgi), .bankBits(bankBits), .ackRvalid(ackRvalid),
    .ackRdata(ackRdata), .pending(pending)
  );

  function automatic logic [127:0] expPend();
    logic [127:0] e = '0;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s++)
        e[c*16+s] = |mdl[s][c];
    return e;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkPend(string tag);
    check(tag, pending, expPend());
  endtask

  task automatic doTrig(int cpu, logic [31:0] d);
    logic [7:0] dst;
    @(negedge clk);
    trigValid = 1'b1; trigCpu = 3'(cpu); trigData = d;
    @(negedge clk);
    trigValid = 1'b0;
    case (d[25:24])
      2'd0: dst = d[23:16];
      2'd1: dst = ~(8'd1 << cpu);
      2'd2: dst = 8'd1 << cpu;
      default: dst = 8'hFF;
    endcase
    for (int c = 0; c < 8; c++)
      if (dst[c]) mdl[d[3:0]][c] = mdl[d[3:0]][c] | (8'd1 << cpu);
  endtask

  task automatic doAck(string tag, int cpu, int sgi);
    logic [7:0]  m = mdl[sgi][cpu];
    logic [31:0] e = 32'h3FF;
    for (int b = 7; b >= 0; b--)
      if (m[b]) e = {19'd0, 3'(b), 6'd0, 4'(sgi)};
    if (m != 0) mdl[sgi][cpu][e[12:10]] = 1'b0;
    @(negedge clk);
    ackValid = 1'b1; ackCpu = 3'(cpu); ackSgi = 4'(sgi);
    @(negedge clk);
    ackValid = 1'b0;
    check({tag, " ackRvalid"}, 128'(ackRvalid), 128'(1));
    check({tag, " ackRdata"}, 128'(ackRdata), 128'(e));
  endtask

  task automatic doBank(bit setOp, int cpu, int sgi, logic [7:0] bits);
    @(negedge clk);
    bankSetValid = setOp; bankClrValid = !setOp;
    bankCpu = 3'(cpu); bankSgi = 4'(sgi); bankBits = bits;
    @(negedge clk);
    bankSetValid = 1'b0; bankClrValid = 1'b0;
    if (setOp) mdl[sgi][cpu] = mdl[sgi][cpu] | bits;
    else       mdl[sgi][cpu] = mdl[sgi][cpu] & ~bits;
  endtask

  task automatic testReset();
    check("R1 pending after reset", pending, '0);
    check("R1 ackRvalid after reset", 128'(ackRvalid), '0);
  endtask

  task automatic testListFilter();
    doTrig(2, 32'h0009_0005);
    checkPend("R2 list filter");
    doTrig(4, 32'hABC0_03F7);
    checkPend("R2 ignored upper bits");
  endtask

  task automatic testOthers();
    doTrig(3, 32'h0100_000A);
    checkPend("R3 all but writer");
  endtask

  task automatic testSelf();
    doTrig(6, 32'h02FF_000B);
    checkPend("R4 writer only");
  endtask

  task automatic testAll();
    doTrig(1, 32'h0300_000C);
    checkPend("R5 all cpus");
  endtask

  task automatic testEmpty();
    doTrig(0, 32'h0000_000D);
    checkPend("R6 empty target");
    doAck("R6 no bitmap", 0, 13);
  endtask

  task automatic testMultiSource();
    doTrig(5, 32'h0004_0009);
    doTrig(1, 32'h0004_0009);
    doTrig(6, 32'h0004_0009);
    checkPend("R8 three sources");
    doAck("R7 lowest first", 2, 9);
    checkPend("R8 still pending after one");
    doAck("R7 second source", 2, 9);
    checkPend("R8 still pending after two");
    doAck("R7 last source", 2, 9);
    checkPend("R8 cleared after last");
  endtask

  task automatic testEmptyAck();
    doAck("R9 empty ack", 2, 9);
    checkPend("R9 nothing changed");
  endtask

  task automatic testBank();
    doBank(1'b1, 7, 14, 8'h90);
    checkPend("R10 set bits");
    doBank(1'b0, 7, 14, 8'h21);
    checkPend("R11 clear unset bits");
    doBank(1'b0, 7, 14, 8'h10);
    checkPend("R11 partial clear keeps pending");
    doAck("R11 remaining source", 7, 14);
    doBank(1'b1, 7, 14, 8'h06);
    doBank(1'b0, 7, 14, 8'h06);
    checkPend("R11 full clear drops pending");
  endtask

  initial begin
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 8; c++)
        mdl[s][c] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testListFilter();
    testOthers();
    testSelf();
    testAll();
    testEmpty();
    testMultiSource();
    testEmptyAck();
    testBank();
    checkPend("R8 final state");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule